// File: doc/BRIEF.md
# Dark-Row Column Offset Canceller

This block sits in a pixel stream between the analog-to-digital converter and the stage that forms polarization sums and differences. Every frame opens with one row of light-shielded pixels. That row is read out exactly like the imaging rows, so each of its values is a pure column offset. The block stores this row as a per-column reference and subtracts each column's reference from every pixel of the imaging rows that follow. Column-to-column offsets are gone before any pixel pairs are combined downstream.

The input is an unsigned pixel stream with a frame-start marker on the first beat of each frame and an end-of-row marker on the last beat of each row. The output is a signed, saturated stream with the same end-of-row markers and a frame-start marker on the first corrected beat. The shielded row itself is never forwarded. The reference is double-banked. A new row becomes active only once it has arrived complete. A malformed shielded row raises a one-cycle error and leaves the previous reference in force.

Top module: `dark_ref_subtractor`

## Requirements
- R1: After reset, all outputs are low and the active reference is zero in every column. Until a well-formed shielded row has been captured, imaging pixels pass through unchanged.
- R2: Beats that arrive after reset and before the first frame-start marker produce no output.
- R3: A beat with in_sof_i high opens the shielded row. That row and all of its beats produce no output beat.
- R4: Each imaging beat yields one output beat one clock later. Its value is the pixel minus the active reference of its column, and the column count restarts at 0 after every end-of-row beat.
- R5: The corrected value saturates to the OUT_W-bit signed range. With the defaults, -512 is the minimum and 511 the maximum.
- R6: out_sof_o is high on the first output beat after each shielded row, and only on that beat. out_eol_o repeats in_eol_i of the beat it came from.
- R7: A shielded row of exactly COLS beats, with end-of-row on the last beat and on no other, replaces the active reference from the next beat on.
- R8: If end-of-row arrives before column COLS-1 of the shielded row, err_o pulses one clock later and the previous reference stays active. Beats after the faulty row are treated as imaging beats.
- R9: If the shielded row reaches column COLS-1 without end-of-row, err_o pulses one clock later. The remaining beats up to end-of-row are dropped, and the previous reference stays active.
- R10: A frame-start marker that arrives inside an unfinished shielded row pulses err_o one clock later and begins a fresh shielded row with that beat.
- R11: Imaging beats beyond column COLS-1 of a row use the reference of column COLS-1.
- R12: A cycle with in_valid_i low produces no output beat and no error, and it does not advance the column count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat present |
| in_data_i | input | PIX_W | Unsigned converted pixel |
| in_sof_i | input | 1 | First beat of a frame (first shielded pixel) |
| in_eol_i | input | 1 | Last beat of a row |
| out_valid_o | output | 1 | Corrected beat present |
| out_data_o | output | OUT_W | Signed corrected pixel |
| out_sof_o | output | 1 | First corrected beat of a frame |
| out_eol_o | output | 1 | Last corrected beat of a row |
| err_o | output | 1 | One-cycle pulse on a malformed shielded row |

## Verification
Every result, whether a corrected beat, its markers or an error pulse, is registered once. It therefore appears in the clock cycle after the rising edge that accepts the input beat. The bench drives each beat on a falling edge and samples all outputs on the next falling edge, so every compare lands in the one cycle where that beat's result is due. A reference change is checked on the first imaging beat after the rising edge that accepts the closing shielded beat. Idle cycles are sampled the same way to confirm that they produce nothing.

// File: rtl/dark_ref_pkg.sv
package dark_ref_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // waiting for first frame start
    PH_DARK  = 2'd1,  // capturing shielded row
    PH_DROP  = 2'd2,  // discarding tail of overlong shielded row
    PH_IMAGE = 2'd3   // correcting imaging rows
  } phase_e;
endpackage

// File: rtl/dark_ref_ctrl.sv
module dark_ref_ctrl
  import dark_ref_pkg::*;
#(
  parameter int COLS = 16,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sof_i,
  input  logic          eol_i,
  output logic          wr_en_o,
  output logic [CW-1:0] wr_col_o,
  output logic          commit_o,
  output logic [CW-1:0] rd_col_o,
  output logic          img_beat_o,
  output logic          img_first_o,
  output logic          err_o
);
  localparam logic [CW-1:0] LAST = CW'(COLS - 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] col_q, col_d, cur_col;
  logic          first_q, first_d;
  logic          start, dark_beat, last_col;

  always_comb begin
    start     = valid_i && sof_i;
    cur_col   = start ? '0 : col_q;
    dark_beat = start || (valid_i && phase_q == PH_DARK);
    last_col  = (cur_col == LAST);
    wr_en_o   = dark_beat;
    wr_col_o  = cur_col;
    commit_o  = dark_beat && eol_i && last_col;
    err_o     = (start && phase_q == PH_DARK)
              || (dark_beat && eol_i && !last_col)
              || (dark_beat && !eol_i && last_col);
    img_beat_o  = valid_i && !start && phase_q == PH_IMAGE;
    img_first_o = first_q;
    rd_col_o    = col_q;
  end

  always_comb begin
    phase_d = phase_q;
    col_d   = col_q;
    first_d = first_q;
    if (dark_beat) begin
      first_d = 1'b1;
      if (eol_i) begin
        phase_d = PH_IMAGE;
        col_d   = '0;
      end else if (last_col) begin
        phase_d = PH_DROP;
        col_d   = '0;
      end else begin
        phase_d = PH_DARK;
        col_d   = cur_col + 1'b1;
      end
    end else if (valid_i && phase_q == PH_DROP) begin
      if (eol_i) phase_d = PH_IMAGE;
    end else if (img_beat_o) begin
      first_d = 1'b0;
      if (eol_i)              col_d = '0;
      else if (col_q != LAST) col_d = col_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      col_q   <= '0;
      first_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      col_q   <= col_d;
      first_q <= first_d;
    end
  end
endmodule

// File: rtl/dark_ref_bank.sv
module dark_ref_bank #(
  parameter int COLS  = 16,
  parameter int PIX_W = 10,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CW-1:0]    wr_col_i,
  input  logic [PIX_W-1:0] wr_data_i,
  input  logic             commit_i,
  input  logic [CW-1:0]    rd_col_i,
  output logic [PIX_W-1:0] rd_data_o
);
  // two banks: capture into the shadow, swap only on a complete row
  logic [PIX_W-1:0] mem_q [2][COLS];
  logic             sel_q;

  assign rd_data_o = mem_q[sel_q][rd_col_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else if (commit_i) sel_q <= ~sel_q;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar c = 0; c < COLS; c++) begin : g_col
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q[b][c] <= '0;
        else if (wr_en_i && (sel_q != b[0]) && (wr_col_i == CW'(c)))
          mem_q[b][c] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/dark_ref_sub.sv
module dark_ref_sub #(
  parameter int PIX_W = 10,
  parameter int OUT_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    beat_i,
  input  logic                    first_i,
  input  logic                    eol_i,
  input  logic                    err_i,
  input  logic [PIX_W-1:0]        pix_i,
  input  logic [PIX_W-1:0]        ref_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] data_o,
  output logic                    sof_o,
  output logic                    eol_o,
  output logic                    err_o
);
  localparam int DW = PIX_W + 1;

  logic signed [DW-1:0]    diff;
  logic signed [OUT_W-1:0] sat;

  assign diff = $signed({1'b0, pix_i}) - $signed({1'b0, ref_i});

  if (OUT_W >= DW) begin : g_wide
    assign sat = OUT_W'(diff);
  end else begin : g_clip
    localparam logic signed [DW-1:0] HI = DW'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [DW-1:0] LO = -DW'(1 << (OUT_W - 1));
    always_comb begin
      if (diff > HI)      sat = OUT_W'(HI);
      else if (diff < LO) sat = OUT_W'(LO);
      else                sat = OUT_W'(diff);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      sof_o   <= 1'b0;
      eol_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= beat_i;
      sof_o   <= beat_i && first_i;
      eol_o   <= beat_i && eol_i;
      err_o   <= err_i;
      if (beat_i) data_o <= sat;
    end
  end
endmodule

// File: rtl/dark_ref_subtractor.sv
module dark_ref_subtractor #(
  parameter int COLS  = 16,
  parameter int PIX_W = 10,
  parameter int OUT_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic [PIX_W-1:0]        in_data_i,
  input  logic                    in_sof_i,
  input  logic                    in_eol_i,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] out_data_o,
  output logic                    out_sof_o,
  output logic                    out_eol_o,
  output logic                    err_o
);
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

  logic             wr_en, commit, img_beat, img_first, err;
  logic [CW-1:0]    wr_col, rd_col;
  logic [PIX_W-1:0] ref_val;

  dark_ref_ctrl #(.COLS(COLS)) i_ctrl (
    .clk_i, .rst_ni,
    .valid_i(in_valid_i), .sof_i(in_sof_i), .eol_i(in_eol_i),
    .wr_en_o(wr_en), .wr_col_o(wr_col), .commit_o(commit),
    .rd_col_o(rd_col), .img_beat_o(img_beat), .img_first_o(img_first),
    .err_o(err)
  );

  dark_ref_bank #(.COLS(COLS), .PIX_W(PIX_W)) i_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_col_i(wr_col), .wr_data_i(in_data_i),
    .commit_i(commit), .rd_col_i(rd_col), .rd_data_o(ref_val)
  );

  dark_ref_sub #(.PIX_W(PIX_W), .OUT_W(OUT_W)) i_sub (
    .clk_i, .rst_ni,
    .beat_i(img_beat), .first_i(img_first), .eol_i(in_eol_i), .err_i(err),
    .pix_i(in_data_i), .ref_i(ref_val),
    .valid_o(out_valid_o), .data_o(out_data_o), .sof_o(out_sof_o),
    .eol_o(out_eol_o), .err_o(err_o)
  );
endmodule

// File: rtl/dark_ref_checker.sv
module dark_ref_checker #(
  parameter int COLS  = 16,
  parameter int PIX_W = 10,
  parameter int OUT_W = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic [PIX_W-1:0]        in_data_i,
  input logic                    in_sof_i,
  input logic                    in_eol_i,
  input logic                    out_valid_o,
  input logic signed [OUT_W-1:0] out_data_o,
  input logic                    out_sof_o,
  input logic                    out_eol_o,
  input logic                    err_o
);
  AST_DARK_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_sof_i |=> !out_valid_o); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o && !err_o); // R12
  AST_SHORT_DARK_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_sof_i && in_eol_i |=> err_o); // R8
  AST_EOL_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_eol_o == $past(in_eol_i)); // R6
  AST_SOF_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sof_o |-> out_valid_o); // R6
  AST_ZERO_NOT_POSITIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(in_data_i) == '0 |-> out_data_o <= 0); // R4
  AST_FULL_NOT_NEGATIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(in_data_i) == {PIX_W{1'b1}} |-> out_data_o >= 0); // R5
endmodule

bind dark_ref_subtractor dark_ref_checker #(.COLS(COLS), .PIX_W(PIX_W), .OUT_W(OUT_W)) i_checker (.*);

// File: tb/test_dark_ref_subtractor.sv
`timescale 1ns/1ps
module test_dark_ref_subtractor;
  localparam int COLS  = 16;
  localparam int PIX_W = 10;
  localparam int OUT_W = 10;
  localparam int PMAX  = (1 << PIX_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [PIX_W-1:0] in_data = '0;
  logic out_valid, out_sof, out_eol, err;
  logic signed [OUT_W-1:0] out_data;

  always #2 clk = ~clk;  // 250 MHz

  dark_ref_subtractor #(.COLS(COLS), .PIX_W(PIX_W), .OUT_W(OUT_W)) i_dark_ref_subtractor (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_sof_i(in_sof), .in_eol_i(in_eol),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_sof_o(out_sof),
    .out_eol_o(out_eol), .err_o(err)
  );

  int n_cmp = 0, n_bad = 0;
  int ref_m [COLS];   // active reference per the requirements
  int stage [COLS+4]; // values for the next shielded row
  int pix   [COLS+4]; // directed imaging values, -1 = random

  function automatic int sat_exp(int d, int r);
    int v = d - r;
    int hi = (1 << (OUT_W - 1)) - 1;
    int lo = -(1 << (OUT_W - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // drive on falling edge, result due on next falling edge
  task automatic beat(input bit v, input int d, input bit s, input bit e,
                      input bit xv, input int xd, input bit xs, input bit xe,
                      input bit xerr, input string tag);
    in_valid = v; in_data = PIX_W'(d); in_sof = s; in_eol = e;
    @(negedge clk);
    n_cmp++;
    if (out_valid !== xv || err !== xerr ||
        (xv && (int'(out_data) !== xd || out_sof !== xs || out_eol !== xe))) begin
      n_bad++;
      $display("FAIL %s: got v=%0b d=%0d sof=%0b eol=%0b err=%0b exp v=%0b d=%0d sof=%0b eol=%0b err=%0b",
               tag, out_valid, out_data, out_sof, out_eol, err, xv, xd, xs, xe, xerr);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
  endtask

  task automatic gap();
    beat(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R12 idle");
  endtask

  // shielded row of n beats from stage[], eol on last if with_eol
  task automatic dark_row(input int n, input bit with_eol, input int err_idx,
                          input bit good, input string tag);
    for (int i = 0; i < n; i++) begin
      beat(1'b1, stage[i], i == 0, with_eol && i == n - 1,
           1'b0, 0, 1'b0, 1'b0, i == err_idx, tag);
    end
    if (good) for (int c = 0; c < COLS; c++) ref_m[c] = stage[c];
  endtask

  task automatic image_row(input int len, input bit first, input bit gaps, input string tag);
    for (int c = 0; c < len; c++) begin
      int d = (pix[c] >= 0) ? pix[c] : int'($urandom_range(PMAX, 0));
      int col = (c < COLS) ? c : COLS - 1;
      beat(1'b1, d, 1'b0, c == len - 1, 1'b1, sat_exp(d, ref_m[col]),
           first && c == 0, c == len - 1, 1'b0, tag);
      if (gaps && c % 3 == 1) gap();
    end
  endtask

  task automatic fill_stage(input int base, input int span);
    for (int i = 0; i < COLS + 4; i++) stage[i] = base + int'($urandom_range(span, 0));
  endtask

  task automatic clear_pix();
    for (int i = 0; i < COLS + 4; i++) pix[i] = -1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < COLS; c++) ref_m[c] = 0;
    clear_pix();
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (out_valid !== 1'b0 || err !== 1'b0 || out_sof !== 1'b0 || out_eol !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset outputs: got v=%0b err=%0b exp 0", out_valid, err);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2: beats before any frame start are dropped
    for (int i = 0; i < 4; i++)
      beat(1'b1, 100 + i, 1'b0, i == 3, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R2 pre-frame");

    // R8 + R1: short shielded row, reference stays at reset zero
    fill_stage(300, 200);
    dark_row(5, 1'b1, 4, 1'b0, "R8 short dark");
    image_row(COLS, 1'b1, 1'b0, "R1 zero reference");

    // R3, R7, R4: good shielded row, random imaging rows with idle gaps
    fill_stage(20, 100);
    dark_row(COLS, 1'b1, -1, 1'b1, "R3 dark silent");
    image_row(COLS, 1'b1, 1'b0, "R4 row0");
    image_row(COLS, 1'b0, 1'b1, "R12 gaps R4");
    image_row(COLS + 3, 1'b0, 1'b0, "R11 long row");
    image_row(COLS, 1'b0, 1'b0, "R4 after long");

    // R5, R7: directed saturation with a new reference
    fill_stage(0, 1023);
    stage[0] = 0; stage[1] = PMAX; stage[2] = 500; stage[3] = 10;
    dark_row(COLS, 1'b1, -1, 1'b1, "R7 new dark");
    pix[0] = PMAX; pix[1] = 0; pix[2] = 500; pix[3] = 0;
    image_row(COLS, 1'b1, 1'b0, "R5 saturate");
    clear_pix();
    image_row(COLS, 1'b0, 1'b0, "R7 uses new ref");

    // R9: overlong shielded row, tail dropped, old reference kept
    fill_stage(900, 100);
    dark_row(COLS + 3, 1'b1, COLS - 1, 1'b0, "R9 long dark");
    image_row(COLS, 1'b1, 1'b0, "R9 old ref kept");

    // R8 again: short row keeps previous reference
    fill_stage(700, 100);
    dark_row(COLS - 1, 1'b1, COLS - 2, 1'b0, "R8 short dark 2");
    image_row(COLS, 1'b1, 1'b0, "R8 old ref kept");

    // R10: frame start during an unfinished shielded row
    fill_stage(400, 50);
    dark_row(6, 1'b0, -1, 1'b0, "R10 partial dark");
    fill_stage(50, 300);
    dark_row(COLS, 1'b1, 0, 1'b1, "R10 restart");
    image_row(COLS, 1'b1, 1'b1, "R10 new ref R6");

    // random frames
    for (int f = 0; f < 20; f++) begin
      fill_stage(0, PMAX);
      dark_row(COLS, 1'b1, -1, 1'b1, "R7 random dark");
      for (int r = 0; r < 4; r++) image_row(COLS, r == 0, r[0], "R4 random");
    end
    gap();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule